// File: doc/BRIEF.md
# Diskette Controller Host Port Window

This block is the byte-wide register window that a host processor uses to drive a four-drive diskette controller. It claims eight consecutive I/O addresses starting at an aligned base address. Host reads return the subsystem status, the type of the most recent completion and the matching result byte. Host writes load a 16-bit pointer to a parameter block in host memory, launch an operation, or reset the subsystem.

A separate command engine consumes the start pulse and the pointer, performs the operation and returns a one-cycle completion carrying a result type and an error bitmap. The window holds that completion and raises an interrupt flag, which the host sees in the status byte. Read data is combinational in the cycle the read strobe is high. Register side effects, such as the pointer load and the flag clear, take effect at the clock edge that ends that cycle.

Top module: `fdc_host_window`

## Requirements
- R1: After power-on reset, paramPtr is 0x0000, startPulse and subsysReset are low, the result type reads 0x00, the result byte reads 0x00, and the status byte shows its two presence bits (bits 3 and 4) set, with the interrupt flag clear.
- R2: Reading offset 0 returns the status byte: bit 0 drive 0 ready, bit 1 drive 1 ready, bit 2 interrupt flag, bit 3 controller present, bit 4 double-density present, bit 5 drive 2 ready, bit 6 drive 3 ready, bit 7 zero. The drive bits follow driveReady[3:0] live, with bit i of driveReady meaning drive i.
- R3: A completion (doneValid high for one cycle) latches doneType. Reading offset 1 then returns that code in bits 1:0 and zeros in bits 7:2.
- R4: When the latched type is 00 (completion with error), reading offset 3 returns the doneErr byte latched with that completion.
- R5: When the latched type is 10, reading offset 3 returns the live drive ready map: bits 3:0 zero, bit 4 drive 2, bit 5 drive 3, bit 6 drive 0, bit 7 drive 1.
- R6: When the latched type is one of the reserved codes 01 or 11, reading offset 3 returns 0x00.
- R7: A write to offset 1 stores the pointer low byte. A later write to offset 2 updates paramPtr to {offset-2 data, stored low byte} at the edge that ends the write cycle. In the cycle after that edge, startPulse is high for exactly one clock.
- R8: If engineBusy is high during the offset-2 write, no start pulse is produced, but paramPtr is still updated.
- R9: A write of any data to offset 7 produces a one-clock subsysReset pulse in the cycle after the write. At the same edge it clears the pointer, the result type, the latched error byte and the interrupt flag.
- R10: A completion sets the interrupt flag. A read of offset 3 clears it, so a following status read shows bit 2 low.
- R11: Reads of offsets 2, 4, 5, 6 and 7, and reads of any address outside the window, return 0x00. Writes to offsets 3 to 6 and writes outside the window change nothing.
- R12: When a completion arrives in the same cycle as a read of offset 3, the interrupt flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ioAddr | input | ADDR_W | Host I/O address |
| ioRd | input | 1 | Host read strobe, one cycle per access |
| ioWr | input | 1 | Host write strobe, one cycle per access |
| ioWrData | input | 8 | Host write data |
| ioRdData | output | 8 | Host read data, valid while ioRd is high |
| driveReady | input | 4 | Per-drive ready lines, bit i is drive i |
| engineBusy | input | 1 | Command engine is running an operation |
| doneValid | input | 1 | One-cycle completion strobe from the engine |
| doneType | input | 2 | Result type code of the completion |
| doneErr | input | 8 | Error bitmap of the completion |
| startPulse | output | 1 | One-cycle operation launch |
| paramPtr | output | 16 | Parameter block pointer for the engine |
| subsysReset | output | 1 | One-cycle subsystem reset pulse |

## Verification
The status byte is read with each drive ready line raised alone and with all four raised. This separates the four drive positions from the fixed presence bits and from the interrupt bit. The result byte is read under every result type code. Asymmetric error patterns are used for type 00, and a single ready drive at a time for type 10, so that a wrong permutation or a wrong multiplexer leg shows up as a distinct value. Pointer writes are tried with the engine idle and with it busy. Accesses to dead offsets and aliased addresses outside the window are followed by reads of the live registers, to catch decode that is too wide. The clash between a completion and a result read in the same cycle, and a reset write that lands on loaded state, check the priority between the set and clear sources.

// File: rtl/fdcw_pkg.sv
package fdcw_pkg;

  localparam int OFS_W = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_STATUS = 3'd0,
    OFS_TYPE   = 3'd1,
    OFS_PTRHI  = 3'd2,
    OFS_RESULT = 3'd3,
    OFS_SPARE4 = 3'd4,
    OFS_SPARE5 = 3'd5,
    OFS_SPARE6 = 3'd6,
    OFS_RESET  = 3'd7
  } ofs_e;

  localparam logic [1:0] TYPE_ERROR = 2'b00;
  localparam logic [1:0] TYPE_READY = 2'b10;

  typedef struct packed {
    logic rdHit;
    ofs_e rdOfs;
    logic wrPtrLo;
    logic wrPtrHi;
    logic wrReset;
    logic rdResult;
  } strobe_t;

endpackage

// File: rtl/fdcw_ctrl.sv
module fdcw_ctrl
  import fdcw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic              engineBusy,
  output strobe_t           strb,
  output logic              startPulse,
  output logic              subsysReset
);

  localparam int TAG_W = ADDR_W - OFS_W;
  localparam logic [TAG_W-1:0] BASE_TAG = BASE_ADDR[ADDR_W-1:OFS_W];

  logic inWindow;
  ofs_e ofs;

  assign inWindow = (ioAddr[ADDR_W-1:OFS_W] == BASE_TAG);
  assign ofs      = ofs_e'(ioAddr[OFS_W-1:0]);

  always_comb begin
    strb          = '0;
    strb.rdOfs    = ofs;
    strb.rdHit    = ioRd && inWindow;
    strb.rdResult = ioRd && inWindow && (ofs == OFS_RESULT);
    strb.wrPtrLo  = ioWr && inWindow && (ofs == OFS_TYPE);
    strb.wrPtrHi  = ioWr && inWindow && (ofs == OFS_PTRHI);
    strb.wrReset  = ioWr && inWindow && (ofs == OFS_RESET);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPulse  <= 1'b0;
      subsysReset <= 1'b0;
    end else begin
      startPulse  <= strb.wrPtrHi && !engineBusy;
      subsysReset <= strb.wrReset;
    end
  end

endmodule

// File: rtl/fdcw_datapath.sv
module fdcw_datapath
  import fdcw_pkg::*;
#(
  parameter int  NUM_DRIVES = 4,
  parameter bit  CTRL_PRESENT = 1'b1,
  parameter bit  DD_PRESENT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strb,
  input  logic [7:0]            wrData,
  input  logic [NUM_DRIVES-1:0] driveReady,
  input  logic                  doneValid,
  input  logic [1:0]            doneType,
  input  logic [7:0]            doneErr,
  output logic [7:0]            rdData,
  output logic [15:0]           paramPtr,
  output logic                  irqState
);

  logic [7:0] ptrLo;
  logic [1:0] resType;
  logic [7:0] resErr;
  logic [7:0] statusByte;
  logic [7:0] readyMap;
  logic [7:0] resultByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrLo    <= '0;
      paramPtr <= '0;
      resType  <= TYPE_ERROR;
      resErr   <= '0;
      irqState <= 1'b0;
    end else if (strb.wrReset) begin
      ptrLo    <= '0;
      paramPtr <= '0;
      resType  <= TYPE_ERROR;
      resErr   <= '0;
      irqState <= 1'b0;
    end else begin
      if (strb.wrPtrLo) ptrLo <= wrData;
      if (strb.wrPtrHi) paramPtr <= {wrData, ptrLo};
      if (doneValid) begin
        resType <= doneType;
        resErr  <= doneErr;
      end
      if (doneValid)          irqState <= 1'b1;
      else if (strb.rdResult) irqState <= 1'b0;
    end
  end

  always_comb begin
    statusByte = {1'b0, driveReady[3], driveReady[2], DD_PRESENT, CTRL_PRESENT,
                  irqState, driveReady[1], driveReady[0]};
    readyMap   = {driveReady[1], driveReady[0], driveReady[3], driveReady[2], 4'b0000};
    unique case (resType)
      TYPE_ERROR: resultByte = resErr;
      TYPE_READY: resultByte = readyMap;
      default:    resultByte = 8'h00;
    endcase
  end

  always_comb begin
    rdData = 8'h00;
    if (strb.rdHit) begin
      unique case (strb.rdOfs)
        OFS_STATUS: rdData = statusByte;
        OFS_TYPE:   rdData = {6'b000000, resType};
        OFS_RESULT: rdData = resultByte;
        default:    rdData = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/fdc_host_window.sv
module fdc_host_window
  import fdcw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40,
  parameter bit CTRL_PRESENT = 1'b1,
  parameter bit DD_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRd,
  input  logic              ioWr,
  input  logic [7:0]        ioWrData,
  output logic [7:0]        ioRdData,
  input  logic [3:0]        driveReady,
  input  logic              engineBusy,
  input  logic              doneValid,
  input  logic [1:0]        doneType,
  input  logic [7:0]        doneErr,
  output logic              startPulse,
  output logic [15:0]       paramPtr,
  output logic              subsysReset
);

  localparam int NUM_DRIVES = 4;

  strobe_t strb;
  logic    irqState;

  fdcw_ctrl #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .ioAddr      (ioAddr),
    .ioRd        (ioRd),
    .ioWr        (ioWr),
    .engineBusy  (engineBusy),
    .strb        (strb),
    .startPulse  (startPulse),
    .subsysReset (subsysReset)
  );

  fdcw_datapath #(
    .NUM_DRIVES   (NUM_DRIVES),
    .CTRL_PRESENT (CTRL_PRESENT),
    .DD_PRESENT   (DD_PRESENT)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (ioWrData),
    .driveReady (driveReady),
    .doneValid  (doneValid),
    .doneType   (doneType),
    .doneErr    (doneErr),
    .rdData     (ioRdData),
    .paramPtr   (paramPtr),
    .irqState   (irqState)
  );

endmodule

// File: rtl/fdcw_chk.sv
module fdcw_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h40
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioRd,
  input logic              ioWr,
  input logic [7:0]        ioWrData,
  input logic [7:0]        ioRdData,
  input logic              engineBusy,
  input logic              doneValid,
  input logic              startPulse,
  input logic [15:0]       paramPtr,
  input logic              subsysReset,
  input logic              irqState
);

  localparam logic [ADDR_W-1:0] PTRHI_ADDR = BASE_ADDR + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] RESET_ADDR = BASE_ADDR + ADDR_W'(7);

  logic inWin;
  assign inWin = (ioAddr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3]);

  // R7: a start pulse follows an offset-2 write and carries its data as the high byte
  a_r7_start_source: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> ($past(ioWr) && $past(ioAddr) == PTRHI_ADDR
                    && paramPtr[15:8] == $past(ioWrData)));

  // R8: no launch while the engine was busy
  a_r8_no_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> $past(!engineBusy));

  // R9: reset pulse comes from an offset-7 write and leaves cleared state
  a_r9_reset_source: assert property (@(posedge clk) disable iff (!rstN)
    subsysReset |-> ($past(ioWr) && $past(ioAddr) == RESET_ADDR));

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    subsysReset |-> (paramPtr == 16'h0000 && !irqState));

  // R10 and R12: a completion always leaves the flag set unless a reset write hit
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    ($past(doneValid) && !subsysReset) |-> irqState);

  // R11: nothing is driven for addresses outside the window
  a_r11_outside_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ioRd && !inWin) |-> ioRdData == 8'h00);

endmodule

bind fdc_host_window fdcw_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (.*);

// File: tb/fdc_host_window_tb.sv
`timescale 1ns/1ps
module fdc_host_window_tb;

  localparam logic [7:0] BASE = 8'h40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ioAddr = '0;
  logic        ioRd = 1'b0;
  logic        ioWr = 1'b0;
  logic [7:0]  ioWrData = '0;
  logic [7:0]  ioRdData;
  logic [3:0]  driveReady = '0;
  logic        engineBusy = 1'b0;
  logic        doneValid = 1'b0;
  logic [1:0]  doneType = '0;
  logic [7:0]  doneErr = '0;
  logic        startPulse;
  logic [15:0] paramPtr;
  logic        subsysReset;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fdc_host_window #(.ADDR_W(8), .BASE_ADDR(BASE)) u_dut (
    .clk(clk), .rstN(rstN), .ioAddr(ioAddr), .ioRd(ioRd), .ioWr(ioWr),
    .ioWrData(ioWrData), .ioRdData(ioRdData), .driveReady(driveReady),
    .engineBusy(engineBusy), .doneValid(doneValid), .doneType(doneType),
    .doneErr(doneErr), .startPulse(startPulse), .paramPtr(paramPtr),
    .subsysReset(subsysReset)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rdPort(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    ioAddr = a; ioRd = 1'b1;
    #1 v = ioRdData;
    @(negedge clk);
    ioRd = 1'b0;
  endtask

  task automatic wrPort(input logic [7:0] a, input logic [7:0] d,
                        output logic s1, output logic s2, output logic r1, output logic r2);
    @(negedge clk);
    ioAddr = a; ioWr = 1'b1; ioWrData = d;
    @(negedge clk);
    ioWr = 1'b0;
    s1 = startPulse; r1 = subsysReset;
    @(negedge clk);
    s2 = startPulse; r2 = subsysReset;
  endtask

  task automatic complete(input logic [1:0] t, input logic [7:0] e);
    @(negedge clk);
    doneValid = 1'b1; doneType = t; doneErr = e;
    @(negedge clk);
    doneValid = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    driveReady = 4'b0000;
    check("R1 ptr", paramPtr, 16'h0000);
    check("R1 start", {15'd0, startPulse}, 16'd0);
    check("R1 sreset", {15'd0, subsysReset}, 16'd0);
    rdPort(BASE + 8'd0, v); check("R1 status", {8'd0, v}, 16'h0018);
    rdPort(BASE + 8'd1, v); check("R1 type", {8'd0, v}, 16'h0000);
    rdPort(BASE + 8'd3, v); check("R1 result", {8'd0, v}, 16'h0000);
  endtask

  task automatic t_status();
    logic [7:0] v;
    logic [7:0] expv [5] = '{8'h19, 8'h1A, 8'h38, 8'h58, 8'h7B};
    logic [3:0] pat  [5] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1111};
    for (int i = 0; i < 5; i++) begin
      driveReady = pat[i];
      rdPort(BASE, v);
      check("R2 status map", {8'd0, v}, {8'd0, expv[i]});
    end
    driveReady = 4'b0000;
  endtask

  task automatic t_errResult();
    logic [7:0] v;
    complete(2'b00, 8'hA5);
    rdPort(BASE + 8'd1, v); check("R3 type err", {8'd0, v}, 16'h0000);
    rdPort(BASE + 8'd0, v); check("R10 flag set", {15'd0, v[2]}, 16'd1);
    rdPort(BASE + 8'd3, v); check("R4 err byte A5", {8'd0, v}, 16'h00A5);
    rdPort(BASE + 8'd0, v); check("R10 flag cleared", {15'd0, v[2]}, 16'd0);
    complete(2'b00, 8'h5A);
    rdPort(BASE + 8'd3, v); check("R4 err byte 5A", {8'd0, v}, 16'h005A);
  endtask

  task automatic t_readyMap();
    logic [7:0] v;
    logic [7:0] expv [4] = '{8'h40, 8'h80, 8'h10, 8'h20};
    complete(2'b10, 8'hFF);
    rdPort(BASE + 8'd1, v); check("R3 type ready", {8'd0, v}, 16'h0002);
    for (int i = 0; i < 4; i++) begin
      driveReady = 4'b0001 << i;
      rdPort(BASE + 8'd3, v);
      check("R5 ready map", {8'd0, v}, {8'd0, expv[i]});
    end
    driveReady = 4'b0000;
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    driveReady = 4'b1111;
    complete(2'b01, 8'hFF);
    rdPort(BASE + 8'd1, v); check("R3 type 01", {8'd0, v}, 16'h0001);
    rdPort(BASE + 8'd3, v); check("R6 reserved 01", {8'd0, v}, 16'h0000);
    complete(2'b11, 8'hFF);
    rdPort(BASE + 8'd1, v); check("R3 type 11", {8'd0, v}, 16'h0003);
    rdPort(BASE + 8'd3, v); check("R6 reserved 11", {8'd0, v}, 16'h0000);
    driveReady = 4'b0000;
  endtask

  task automatic t_clash();
    logic [7:0] v;
    @(negedge clk);
    ioAddr = BASE + 8'd3; ioRd = 1'b1;
    doneValid = 1'b1; doneType = 2'b00; doneErr = 8'h11;
    @(negedge clk);
    ioRd = 1'b0; doneValid = 1'b0;
    rdPort(BASE, v); check("R12 set wins", {15'd0, v[2]}, 16'd1);
    rdPort(BASE + 8'd3, v); check("R4 clash byte", {8'd0, v}, 16'h0011);
  endtask

  task automatic t_start();
    logic s1, s2, r1, r2;
    engineBusy = 1'b0;
    wrPort(BASE + 8'd1, 8'h34, s1, s2, r1, r2);
    check("R7 no pulse on low", {15'd0, s1}, 16'd0);
    wrPort(BASE + 8'd2, 8'h12, s1, s2, r1, r2);
    check("R7 pulse", {15'd0, s1}, 16'd1);
    check("R7 pulse ends", {15'd0, s2}, 16'd0);
    check("R7 ptr", paramPtr, 16'h1234);
  endtask

  task automatic t_busy();
    logic s1, s2, r1, r2;
    engineBusy = 1'b1;
    wrPort(BASE + 8'd1, 8'h78, s1, s2, r1, r2);
    wrPort(BASE + 8'd2, 8'h56, s1, s2, r1, r2);
    check("R8 no pulse busy", {14'd0, s1, s2}, 16'd0);
    check("R8 ptr busy", paramPtr, 16'h5678);
    engineBusy = 1'b0;
  endtask

  task automatic t_resetWrite();
    logic s1, s2, r1, r2;
    logic [7:0] v;
    complete(2'b10, 8'h00);
    complete(2'b00, 8'hC3);
    wrPort(BASE + 8'd7, 8'h00, s1, s2, r1, r2);
    check("R9 reset pulse", {14'd0, r1, r2}, 16'b10);
    check("R9 ptr cleared", paramPtr, 16'h0000);
    rdPort(BASE + 8'd1, v); check("R9 type cleared", {8'd0, v}, 16'h0000);
    rdPort(BASE + 8'd3, v); check("R9 err cleared", {8'd0, v}, 16'h0000);
    rdPort(BASE + 8'd0, v); check("R9 flag cleared", {15'd0, v[2]}, 16'd0);
  endtask

  task automatic t_unused();
    logic s1, s2, r1, r2;
    logic [7:0] v;
    logic [7:0] ofs [5] = '{8'd2, 8'd4, 8'd5, 8'd6, 8'd7};
    complete(2'b00, 8'h3C);
    for (int i = 0; i < 5; i++) begin
      rdPort(BASE + ofs[i], v);
      check("R11 dead offset read", {8'd0, v}, 16'h0000);
    end
    rdPort(BASE + 8'd8, v);  check("R11 outside read", {8'd0, v}, 16'h0000);
    rdPort(BASE - 8'd5, v);  check("R11 below read", {8'd0, v}, 16'h0000);
    wrPort(BASE + 8'd1, 8'h21, s1, s2, r1, r2);
    wrPort(BASE + 8'd9, 8'hEE, s1, s2, r1, r2);
    check("R11 outside write pulses", {14'd0, s1, r1}, 16'd0);
    wrPort(BASE + 8'd15, 8'h00, s1, s2, r1, r2);
    check("R11 outside reset alias", {15'd0, r1}, 16'd0);
    for (int o = 3; o < 7; o++) begin
      wrPort(BASE + 8'(o), 8'hFF, s1, s2, r1, r2);
      check("R11 dead write pulses", {14'd0, s1, r1}, 16'd0);
    end
    rdPort(BASE + 8'd3, v); check("R11 result kept", {8'd0, v}, 16'h003C);
    wrPort(BASE + 8'd2, 8'h9A, s1, s2, r1, r2);
    check("R11 low byte kept", paramPtr, 16'h9A21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_errResult();
    t_readyMap();
    t_reserved();
    t_clash();
    t_start();
    t_busy();
    t_resetWrite();
    t_unused();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule